// File: doc/BRIEF.md
# Programmable Pin-to-Control-Bit Mapper

This block sits between a host's narrow register port and eight physical pins. The host shares one 10-bit bus for addresses and data. A low select line marks control-register traffic, and a read/write line picks the direction. Every transfer takes two strobe rising edges: the first latches a register address and the second carries the data. The strobe comes from another clock domain, so it is resynchronised into the system clock before any edge is detected.

The block holds a 64-bit control/status bit space. Indices 16 to 31 are live status inputs from the video datapath and cannot be written. Every other index is a stored control bit. Each of the eight pins has a configuration register with a 6-bit code that picks one index of this space, plus a 2-bit direction field. An output pin drives the chosen bit at all times. An input pin copies its level into the chosen bit on every strobe event. Pins that are not driving are tri-stated through a separate enable.

Top module: `iopin_map`

## Requirements
- R1: After reset every configuration code and direction field is 0, every control bit is 0, and every pin_oe and pin_out bit is 0.
- R2: With ctl_sel_n low and rd_wr_n low, one strobe edge latches bus_din as the address and the next strobe edge writes bus_din as data. At address 0x00F+p (p = 0..7), bits [5:0] load pin p's code and bits [9:8] load its direction. At address a in 0..7, bits [7:0] load control indices 8a..8a+7.
- R3: When rd_wr_n is high, the data phase writes nothing. When ctl_sel_n is high, strobe edges are ignored and the block returns to the address phase.
- R4: bus_dout shows the register at the last latched address. For a in 0..7 it gives indices 8a..8a+7 in bits [7:0]. For a pin configuration register it gives {dir, 2'b00, code}. Every other address reads 0.
- R5: Indices 16..31 read as status_in[index-16]. Host writes and input pins cannot change them.
- R6: A pin whose code is nonzero and whose direction is nonzero has pin_oe=1. Its pin_out follows the selected bit, including status changes, with no strobe needed.
- R7: A pin whose code is nonzero, whose direction is 0, and whose code selects a writable index stores its pin_in level into that index on each strobe event. Its level has no effect before that event.
- R8: Code 0 assigns no bit. A pin with code 0, or an input pin that selects a status index, has pin_oe=0 and pin_out=0, and its pin_in has no effect.
- R9: Each strobe rising edge gives exactly one event, however long the strobe stays high.
- R10: When input pins and a host write target the same index in one event, the pin level wins. Among several pins, the highest pin number wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_din | input | 10 | Shared address/data bus from the host |
| ctl_sel_n | input | 1 | Low selects control-register access |
| rd_wr_n | input | 1 | High for read, low for write |
| strobe | input | 1 | Asynchronous host transfer strobe |
| bus_dout | output | 10 | Readback of the addressed register |
| status_in | input | 16 | Status bits from the datapath (indices 16..31) |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The assertions check four things on every cycle. A strobe edge yields an event that never lasts two cycles. A high ctl_sel_n puts the transfer back in the address phase. The stored control bits and the pin enables change only after an event. The status slice of the store is never written. Only the bench scenarios can show the contents of the bit mapping. These cover which index a code reaches, the priority when a pin and the host write in the same event, the live following of status inputs by output pins, and the inert behaviour of code 0. The bench checks each of these against its own model of the bit space.

// File: rtl/iopin_map.sv
module iopin_map #(
  parameter int NPIN     = 8,
  parameter int DW       = 10,
  parameter int CW       = 6,
  parameter int CFG_BASE = 15,
  parameter int STAT_LO  = 16,
  parameter int STAT_N   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     bus_din,
  input  logic              ctl_sel_n,
  input  logic              rd_wr_n,
  input  logic              strobe,
  output logic [DW-1:0]     bus_dout,
  input  logic [STAT_N-1:0] status_in,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  localparam int NB   = 2**CW;
  localparam int NGRP = NB/8;
  localparam int GW   = $clog2(NGRP);

  logic [2:0]    sync_q;
  logic          evt, phase_q;
  logic [DW-1:0] addr_q;
  logic [CW-1:0] code_q [NPIN];
  logic [1:0]    dir_q  [NPIN];
  logic [NB-1:0] ctrl_q, ctrl_d, bitv;
  logic          host_wr, grp_hit;

  function automatic logic writable(int i);
    return !(i >= STAT_LO && i < STAT_LO + STAT_N);
  endfunction

  assign evt     = sync_q[1] & ~sync_q[2];
  assign host_wr = evt & phase_q & ~ctl_sel_n & ~rd_wr_n;
  assign grp_hit = addr_q < DW'(NGRP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      phase_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], strobe};
      if (ctl_sel_n) phase_q <= 1'b0;
      else if (evt) begin
        phase_q <= ~phase_q;
        if (!phase_q) addr_q <= bus_din;
      end
    end
  end

  always_comb begin
    bitv = ctrl_q;
    bitv[STAT_LO +: STAT_N] = status_in;
  end

  always_comb begin
    int base;
    ctrl_d = ctrl_q;
    base = int'(addr_q[GW-1:0]) * 8;
    if (host_wr && grp_hit)
      for (int b = 0; b < 8; b++)
        if (writable(base + b)) ctrl_d[CW'(base + b)] = bus_din[b];
    if (evt)
      for (int p = 0; p < NPIN; p++)
        if (code_q[p] != '0 && dir_q[p] == 2'b00 && writable(int'(code_q[p])))
          ctrl_d[code_q[p]] = pin_in[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q[p] <= '0;
        dir_q[p]  <= '0;
      end else if (host_wr && addr_q == DW'(CFG_BASE + p)) begin
        code_q[p] <= bus_din[CW-1:0];
        dir_q[p]  <= bus_din[DW-1:DW-2];
      end
    end
    assign pin_oe[p]  = (code_q[p] != '0) && (dir_q[p] != 2'b00);
    assign pin_out[p] = pin_oe[p] & bitv[code_q[p]];
  end

  always_comb begin
    int base;
    bus_dout = '0;
    base = int'(addr_q[GW-1:0]) * 8;
    if (grp_hit) begin
      for (int b = 0; b < 8; b++) bus_dout[b] = bitv[CW'(base + b)];
    end else begin
      for (int p = 0; p < NPIN; p++)
        if (addr_q == DW'(CFG_BASE + p)) begin
          bus_dout[CW-1:0]     = code_q[p];
          bus_dout[DW-1:DW-2]  = dir_q[p];
        end
    end
  end
endmodule

module iopin_map_chk #(
  parameter int NPIN = 8, parameter int NB = 64,
  parameter int STAT_LO = 16, parameter int STAT_N = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            evt,
  input logic            phase_q,
  input logic            ctl_sel_n,
  input logic [NB-1:0]   ctrl_q,
  input logic [NPIN-1:0] pin_oe
);
  // R9
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n) evt |=> !evt);
  // R3
  sel_high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) ctl_sel_n |=> !phase_q);
  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !evt |=> $stable(ctrl_q));
  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !evt |=> $stable(pin_oe));
  // R5
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) ctrl_q[STAT_LO +: STAT_N] == '0);
endmodule

bind iopin_map iopin_map_chk #(.NPIN(NPIN), .NB(NB), .STAT_LO(STAT_LO), .STAT_N(STAT_N)) u_chk (.*);

// File: tb/sim_iopin_map.sv
module sim_iopin_map;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [9:0] bus_din = '0;
  logic ctl_sel_n = 1, rd_wr_n = 1, strobe = 0;
  logic [9:0] bus_dout;
  logic [15:0] status_in = '0;
  logic [7:0] pin_in = '0, pin_out, pin_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] ctrl_m;
  logic [5:0]  code_m [8];
  logic [1:0]  dir_m  [8];
  logic        phase_m;
  logic [9:0]  addr_m;

  iopin_map u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic wok(int i);
    return !(i >= 16 && i < 32);
  endfunction

  function automatic logic [63:0] bitv_m();
    logic [63:0] v = ctrl_m;
    v[31:16] = status_in;
    return v;
  endfunction

  function automatic logic [9:0] rd_m(logic [9:0] a);
    logic [63:0] v = bitv_m();
    if (a < 8) return {2'b00, v[a*8 +: 8]};
    if (a >= 15 && a < 23) return {dir_m[a-15], 2'b00, code_m[a-15]};
    return '0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_evt();
    logic [63:0] n = ctrl_m;
    logic [5:0] nc [8];
    logic [1:0] nd [8];
    for (int p = 0; p < 8; p++) begin nc[p] = code_m[p]; nd[p] = dir_m[p]; end
    if (!ctl_sel_n) begin
      if (!phase_m) addr_m = bus_din;
      else if (!rd_wr_n) begin
        if (addr_m < 8)
          for (int b = 0; b < 8; b++) if (wok(addr_m*8+b)) n[addr_m*8+b] = bus_din[b];
        if (addr_m >= 15 && addr_m < 23) begin
          nc[addr_m-15] = bus_din[5:0]; nd[addr_m-15] = bus_din[9:8];
        end
      end
      phase_m = ~phase_m;
    end
    for (int p = 0; p < 8; p++)
      if (code_m[p] != 0 && dir_m[p] == 0 && wok(code_m[p])) n[code_m[p]] = pin_in[p];
    ctrl_m = n;
    for (int p = 0; p < 8; p++) begin code_m[p] = nc[p]; dir_m[p] = nd[p]; end
  endtask

  task automatic pulse(int width);
    model_evt();
    strobe = 1;
    repeat (width) @(negedge clk);
    strobe = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    ctl_sel_n = 1; phase_m = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(logic [9:0] a, logic [9:0] d);
    ctl_sel_n = 0; rd_wr_n = 0;
    bus_din = a; pulse(4);
    bus_din = d; pulse(4);
  endtask

  task automatic rd_check(logic [9:0] a, string req);
    ctl_sel_n = 0; rd_wr_n = 1; bus_din = a;
    pulse(4);
    #1 check(req, bus_dout, rd_m(a));
    sel_off();
  endtask

  task automatic pins_check(string req);
    logic [63:0] v = bitv_m();
    #1;
    for (int p = 0; p < 8; p++) begin
      logic eoe = (code_m[p] != 0) && (dir_m[p] != 0);
      check({req, " oe"}, pin_oe[p], eoe);
      check({req, " out"}, pin_out[p], eoe & v[code_m[p]]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    ctrl_m = '0; phase_m = 0; addr_m = '0;
    for (int p = 0; p < 8; p++) begin code_m[p] = 0; dir_m[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    #1 check("R1 oe", pin_oe, 0);
    check("R1 out", pin_out, 0);
    check("R1 dout", bus_dout, 0);

    // R2 R6 R8 sweep every code on pin 0 as output
    status_in = 16'hA5C3;
    wr(0, 10'h0F0); wr(5, 10'h05A); wr(6, 10'h0C3);
    sel_off();
    for (int c = 0; c < 64; c++) begin
      wr(10'h00F, 10'h300 | c);
      sel_off();
      pins_check("R6 R8 sweep");
    end
    rd_check(10'h00F, "R4 cfg readback");
    wr(10'h00F, 10'h310); sel_off();
    pins_check("R2 luma crc map");

    // program all pins
    wr(10'h00F, 10'h310); wr(10'h010, 10'h115); wr(10'h011, 10'h21F); wr(10'h012, 10'h328);
    wr(10'h013, 10'h005); wr(10'h014, 10'h009); wr(10'h015, 10'h021); wr(10'h016, 10'h012);
    sel_off();
    for (int i = 0; i < 8; i++) rd_check(10'(15 + i), "R4 cfg all");
    // R6 outputs follow status without strobe
    for (int s = 0; s < 256; s++) begin
      status_in = 16'(s * 257 ^ (s << 3));
      @(negedge clk);
      pins_check("R6 status follow");
    end

    // R4 R5 group writes and readback
    for (int g = 0; g < 8; g++) wr(10'(g), 10'(g * 37 + 5));
    sel_off();
    for (int g = 0; g < 10; g++) rd_check(10'(g), "R5 R4 group");
    rd_check(10'h100, "R4 unmapped");

    // R7 input path: level has no effect before a strobe
    for (int v = 0; v < 16; v++) begin
      pin_in = 8'(v << 4);
      repeat (3) @(negedge clk);
      #1 check("R7 pre-strobe", bus_dout, rd_m(addr_m));
      rd_check(0, "R7 group0");
      rd_check(1, "R7 group1");
      rd_check(4, "R7 group4");
      rd_check(2, "R8 status idle");
    end

    // R3 read data phase and deselected strobes write nothing
    ctl_sel_n = 0; rd_wr_n = 1; bus_din = 3; pulse(4);
    bus_din = 10'h3FF; pulse(4);
    sel_off();
    rd_check(3, "R3 read phase");
    ctl_sel_n = 0; rd_wr_n = 0; bus_din = 7; pulse(4);
    ctl_sel_n = 1; phase_m = 0; bus_din = 10'h0AA; pulse(4);
    ctl_sel_n = 0; bus_din = 10'h0AA; pulse(4);
    sel_off();
    check("R3 deselect", bus_dout, rd_m(10'h0AA));
    rd_check(7, "R3 group7");

    // R10 pin wins over host, highest pin wins
    wr(10'h014, 10'h005); sel_off();
    pin_in = 8'h20;
    wr(0, 10'h000); sel_off();
    rd_check(0, "R10 pin priority");
    check("R10 bit5", ctrl_m[5], 1'b1);
    pin_in = 8'h10;
    wr(0, 10'h0FF); sel_off();
    rd_check(0, "R10 high pin");

    // R9 long strobe gives one event
    ctl_sel_n = 0; rd_wr_n = 0; bus_din = 6; pulse(20);
    bus_din = 10'h06D; pulse(4);
    sel_off();
    rd_check(6, "R9 long strobe");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule